// File: doc/BRIEF.md
# Signed ALU with Condition-Code Flags

This block is the execute stage arithmetic of a small two-operand integer core. Each cycle it receives a 4-bit operation select and two 32-bit operands, called the source (A) and the destination (B). It drives a combinational result that the surrounding pipeline writes back over the destination register. The operations are add, subtract (destination minus source), bitwise AND and bitwise XOR. Because the destination is overwritten, subtraction is always ordered as B minus A.

Next to the datapath sits a three-bit condition register. It holds signed overflow, zero and negative. There is no carry, so all operands are read as two's-complement signed values. The decoder raises a flag-update strobe only for arithmetic and logical instructions. On that clock edge the register captures the flags of the current result. Move instructions leave the strobe low, so the flags keep their value through any number of them.

The result path is purely combinational and the flag register loads unconditionally when enabled. There is therefore no stream handshake and no back-pressure: one operation is presented per cycle, and its flags are visible after the next rising edge.

Top module: `alu_cc_unit`

## Requirements
- R1: With op_sel = 0 the result is op_b + op_a, modulo 2^32.
- R2: With op_sel = 1 the result is op_b - op_a, modulo 2^32.
- R3: With op_sel = 2 the result is op_b AND op_a. With op_sel = 3 it is op_b XOR op_a.
- R4: When upd_flags is high on a rising edge and op_sel is 0 to 3, flag_zf becomes 1 exactly when the result is zero, and flag_sf becomes bit 31 of the result, from the cycle after that edge.
- R5: On such an edge with op_sel = 0, flag_of becomes 1 exactly when the signed sum of the operands lies outside [-2^31, 2^31-1].
- R6: On such an edge with op_sel = 1, flag_of becomes 1 exactly when the signed difference op_b - op_a lies outside [-2^31, 2^31-1].
- R7: On such an edge with op_sel = 2 or 3, flag_of becomes 0.
- R8: While upd_flags is low, all three flags keep their value across the edge.
- R9: For op_sel = 4 to 15 the result is zero, and the flags keep their value even when upd_flags is high.
- R10: When rst is high on a rising edge, all three flags become 0, whatever upd_flags is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the flag register |
| op_sel | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR, others unused |
| op_a | input | 32 | Source operand |
| op_b | input | 32 | Destination operand |
| upd_flags | input | 1 | Capture flags of this operation at the edge |
| result | output | 32 | Combinational result, written back to the destination |
| flag_of | output | 1 | Registered signed overflow |
| flag_zf | output | 1 | Registered zero flag |
| flag_sf | output | 1 | Registered negative flag |

## Verification
The bench targets overflow at both signed limits. It adds two large positives, subtracts 1 from the most negative value, and subtracts -1 from the most positive value. A design that computed A minus B, or used the source sign in the subtract overflow test, would report the wrong sign or miss the overflow. A logical operation follows an overflowing add, which catches a design that leaves OF set. Equal operands are XORed to reach exactly zero, which catches a faulty ZF. Flag-holding is checked with the strobe low and with an unused op_sel under a high strobe. A design that loaded on the strobe alone would show new flags there. Reset is asserted together with a high strobe, to catch a design that lets the load win.

// File: rtl/alu_cc_pkg.sv
`timescale 1ns/1ps
package alu_cc_pkg;
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_ADD = 4'd0;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'd1;
  localparam logic [SEL_W-1:0] SEL_AND = 4'd2;
  localparam logic [SEL_W-1:0] SEL_XOR = 4'd3;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic neg;
  } cc_flags_t;
endpackage

// File: rtl/alu_exec.sv
`timescale 1ns/1ps
module alu_exec
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     dst,
  output logic [W-1:0]     res,
  output cc_flags_t        flags,
  output logic             sel_ok
);
  localparam int MSB = W - 1;

  logic          is_sub;
  logic [W-1:0]  addend;
  logic [W-1:0]  sum;
  logic          arith_ovf;

  // One shared adder: subtraction adds the inverted source plus one.
  assign is_sub = (sel == SEL_SUB);
  assign addend = is_sub ? ~src : src;
  assign sum    = dst + addend + {{(W-1){1'b0}}, is_sub};

  // Overflow when both adder inputs share a sign the sum does not.
  assign arith_ovf = (dst[MSB] == addend[MSB]) && (sum[MSB] != dst[MSB]);

  always_comb begin
    sel_ok = 1'b1;
    unique case (sel)
      SEL_ADD, SEL_SUB: res = sum;
      SEL_AND:          res = dst & src;
      SEL_XOR:          res = dst ^ src;
      default: begin
        res    = '0;
        sel_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    flags.ovf  = (sel == SEL_ADD || sel == SEL_SUB) ? arith_ovf : 1'b0;
    flags.zero = (res == '0);
    flags.neg  = res[MSB];
  end
endmodule

// File: rtl/cc_register.sv
`timescale 1ns/1ps
module cc_register
  import alu_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  cc_flags_t d,
  output cc_flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu_cc_unit.sv
`timescale 1ns/1ps
module alu_cc_unit
  import alu_cc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  op_sel,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        upd_flags,
  output logic [31:0] result,
  output logic        flag_of,
  output logic        flag_zf,
  output logic        flag_sf
);
  localparam int DW = 32;

  cc_flags_t next_cc;
  cc_flags_t cur_cc;
  logic      sel_ok;

  alu_exec #(.W(DW)) u_exec (
    .sel    (op_sel),
    .src    (op_a),
    .dst    (op_b),
    .res    (result),
    .flags  (next_cc),
    .sel_ok (sel_ok)
  );

  cc_register u_cc (
    .clk  (clk),
    .rst  (rst),
    .load (upd_flags & sel_ok),
    .d    (next_cc),
    .q    (cur_cc)
  );

  assign flag_of = cur_cc.ovf;
  assign flag_zf = cur_cc.zero;
  assign flag_sf = cur_cc.neg;
endmodule

// File: rtl/alu_cc_checker.sv
`timescale 1ns/1ps
module alu_cc_checker (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  op_sel,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        upd_flags,
  input logic [31:0] result,
  input logic        flag_of,
  input logic        flag_zf,
  input logic        flag_sf
);
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!flag_of && !flag_zf && !flag_sf));

  assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !upd_flags |=> ($stable(flag_of) && $stable(flag_zf) && $stable(flag_sf)));

  assert_unused_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_flags && op_sel > 4'd3) |=>
      ($stable(flag_of) && $stable(flag_zf) && $stable(flag_sf)));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 4'd3) |-> (result == 32'd0));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_flags && op_sel < 4'd4) |=>
      (flag_zf == ($past(result) == 32'd0) && flag_sf == $past(result[31])));

  assert_logic_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_flags && (op_sel == 4'd2 || op_sel == 4'd3)) |=> !flag_of);

  assert_add_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_flags && op_sel == 4'd0) |=>
      (flag_of == (($past(op_a[31]) == $past(op_b[31])) &&
                   ($past(result[31]) != $past(op_a[31])))));

  assert_sub_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_flags && op_sel == 4'd1) |=>
      (flag_of == (($past(op_a[31]) != $past(op_b[31])) &&
                   ($past(result[31]) != $past(op_b[31])))));
endmodule

bind alu_cc_unit alu_cc_checker u_chk (.*);

// File: tb/tb_alu_cc_unit.sv
`timescale 1ns/1ps
module tb_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_sel;
  logic [31:0] op_a, op_b;
  logic        upd_flags;
  logic [31:0] result;
  logic        flag_of, flag_zf, flag_sf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] res;
    logic        of, zf, sf;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic m_of = 0, m_zf = 0, m_sf = 0;

  always #2 clk = ~clk;

  alu_cc_unit dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
    .upd_flags(upd_flags), .result(result),
    .flag_of(flag_of), .flag_zf(flag_zf), .flag_sf(flag_sf)
  );

  task automatic send(input logic [3:0] f, input logic [31:0] a,
                      input logic [31:0] b, input logic s, input logic r,
                      input string tag);
    exp_t e;
    longint sa, sb_v, wide;
    logic [31:0] er;
    logic eo;
    @(negedge clk);
    op_sel = f; op_a = a; op_b = b; upd_flags = s; rst = r;
    sa = longint'($signed(a)); sb_v = longint'($signed(b));
    eo = 1'b0;
    case (f)
      4'd0: begin wide = sb_v + sa; er = b + a; eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      4'd1: begin wide = sb_v - sa; er = b - a; eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      4'd2: er = b & a;
      4'd3: er = b ^ a;
      default: er = 32'd0;
    endcase
    if (r) begin
      m_of = 0; m_zf = 0; m_sf = 0;
    end else if (s && f < 4'd4) begin
      m_of = eo; m_zf = (er == 32'd0); m_sf = er[31];
    end
    e.res = er; e.of = m_of; e.zf = m_zf; e.sf = m_sf; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (result !== e.res || flag_of !== e.of || flag_zf !== e.zf || flag_sf !== e.sf) begin
        errors++;
        $display("FAIL %s: got res=%h of=%b zf=%b sf=%b, expected res=%h of=%b zf=%b sf=%b",
                 e.tag, result, flag_of, flag_zf, flag_sf, e.res, e.of, e.zf, e.sf);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; op_sel = 0; op_a = 0; op_b = 0; upd_flags = 0;
    send(4'd0, 32'd1, 32'd2, 1'b1, 1'b1, "R10 reset");
    send(4'd0, 32'd5, 32'd7, 1'b1, 1'b0, "R1 add");
    send(4'd1, 32'd3, 32'd10, 1'b1, 1'b0, "R2 sub positive");
    send(4'd1, 32'd10, 32'd3, 1'b1, 1'b0, "R2 R4 sub negative");
    send(4'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 1'b0, "R3 and");
    send(4'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 1'b0, "R3 R4 xor zero");
    send(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0, "R5 add overflow");
    send(4'd3, 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, "R7 xor clears of");
    send(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R5 add neg overflow");
    send(4'd2, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1, 1'b0, "R7 and clears of");
    send(4'd1, 32'd1, 32'h8000_0000, 1'b1, 1'b0, "R6 sub min overflow");
    send(4'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R6 sub max overflow");
    send(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, 1'b0, "R6 sub no overflow");
    send(4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R8 hold strobe low");
    send(4'd1, 32'd9, 32'd9, 1'b0, 1'b0, "R8 hold strobe low sub");
    send(4'd7, 32'h1111_1111, 32'h2222_2222, 1'b1, 1'b0, "R9 unused code");
    send(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9 unused code 15");
    send(4'd0, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, "R1 R4 add negative");
    send(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b1, "R10 reset over strobe");
    send(4'd0, 32'h0000_0010, 32'hFFFF_FFF0, 1'b1, 1'b0, "R1 R4 add wrap to zero");
    send(4'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R8 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule